// File: doc/BRIEF.md
# Low-Power Packet Disposition Filter

This block sits at the ingress of a switch port bridge and decides, for every decoded transaction-layer packet header, what the bridge should do with it. Inputs describe the packet: its kind (request, configuration, message or completion), whether a configuration access is type 0, whether the bridge itself is the destination, and whether it came in on the primary or the secondary side. The bridge's power state (D0 or D3hot) selects one of two decision rule sets.

In D0, packets follow the ordinary target decode: anything addressed to the bridge is taken locally and anything else is passed on. In D3hot nearly all requests are refused as unsupported. The exceptions are type 0 configuration traffic and messages for the bridge arriving on the primary side. Completions addressed to the bridge are flagged as unexpected, while completions that only pass through are forwarded exactly as in D0. Each disposition is registered, tagged and held until the next header arrives.

A separate per-source gate decides whether a pending error event may produce an error message. Errors raised by receiving a packet are always reported. Errors from any other cause are dropped while the bridge is in D3hot.

Top module: `lpf_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `disp_valid` is 0 and `err_fire` is all zeros.
- R2: The cycle after `hdr_valid` is sampled high, `disp_valid` is 1, `disp_tag` equals the sampled `hdr_tag`, and the new disposition is shown. Without `hdr_valid`, all disposition outputs keep their values, whatever the header and power inputs do.
- R3: Disposition encoding is 00 accept, 01 forward, 10 unsupported request, 11 unexpected completion. Kind encoding is 00 memory/IO request, 01 configuration, 10 message, 11 completion. In D0 (`pm_d3hot`=0), every kind from either side gives accept when `hdr_to_self`=1 and forward otherwise.
- R4: In D3hot, a configuration packet from the primary side gives accept when `hdr_cfg_type0`=1, whatever `hdr_to_self` is. It gives unsupported request when `hdr_cfg_type0`=0.
- R5: In D3hot, a message from the primary side gives accept when `hdr_to_self`=1 and unsupported request otherwise.
- R6: In D3hot, a memory/IO request from the primary side gives unsupported request, whether or not it targets the bridge.
- R7: In D3hot, every non-completion packet from the secondary side gives unsupported request. This includes configuration packets and messages addressed to the bridge.
- R8: In D3hot, a completion with `hdr_to_self`=1 gives unexpected completion, from either side.
- R9: A completion with `hdr_to_self`=0 gives forward in both power states and from both sides.
- R10: `disp_err_ok` is 1 exactly when the held disposition is unsupported request or unexpected completion.
- R11: `err_fire[i]` is 1 in the cycle after `err_evt[i]` is sampled high, provided `pm_d3hot` was 0 or `err_from_rx[i]` was 1 in that sampled cycle. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_d3hot | input | 1 | 1 = bridge in D3hot, 0 = D0 |
| hdr_valid | input | 1 | Header strobe, one cycle per packet |
| hdr_kind | input | 2 | Packet kind (R3 encoding) |
| hdr_cfg_type0 | input | 1 | Configuration access is type 0 |
| hdr_to_self | input | 1 | Packet is addressed to the bridge |
| hdr_from_secondary | input | 1 | 1 = arrived on secondary side |
| hdr_tag | input | TAG_W | Identifier echoed with the result |
| err_evt | input | ERR_SRCS | Per-source error event pulse |
| err_from_rx | input | ERR_SRCS | Event was caused by packet receipt |
| disp_valid | output | 1 | A disposition is held |
| disp_code | output | 2 | Disposition (R3 encoding) |
| disp_err_ok | output | 1 | Disposition may raise an error message |
| disp_tag | output | TAG_W | Tag of the held disposition |
| err_fire | output | ERR_SRCS | Error message permitted per source |

## Verification
The bench builds the filter with TAG_W=6 and ERR_SRCS=3. A narrow tag lets distinct tag values run across the whole header sweep. Three sources are few enough to drive all eight combinations of event and cause masks in each power state. With these values, all 32 header input combinations can be swept exhaustively in each power state. The sweep covers the conflicts between side and target, such as a message for the bridge arriving on the secondary side, and the hold behaviour while header and power inputs change without a strobe.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

  typedef enum logic [1:0] {
    KIND_REQ = 2'b00,
    KIND_CFG = 2'b01,
    KIND_MSG = 2'b10,
    KIND_CPL = 2'b11
  } pkt_kind_e;

  typedef enum logic [1:0] {
    DISP_ACCEPT  = 2'b00,
    DISP_FORWARD = 2'b01,
    DISP_UR      = 2'b10,
    DISP_UC      = 2'b11
  } disp_e;

  typedef struct packed {
    pkt_kind_e kind;
    logic      cfg_t0;
    logic      to_self;
    logic      from_sec;
  } hdr_t;

  // Full-power rule set: plain target decode.
  function automatic disp_e disp_full_power(input hdr_t h);
    return h.to_self ? DISP_ACCEPT : DISP_FORWARD;
  endfunction

  // Low-power rule set.
  function automatic disp_e disp_low_power(input hdr_t h);
    disp_e d;
    if (h.kind == KIND_CPL) begin
      d = h.to_self ? DISP_UC : DISP_FORWARD;
    end else if (h.from_sec) begin
      d = DISP_UR;
    end else begin
      unique case (h.kind)
        KIND_CFG: d = h.cfg_t0  ? DISP_ACCEPT : DISP_UR;
        KIND_MSG: d = h.to_self ? DISP_ACCEPT : DISP_UR;
        default:  d = DISP_UR;
      endcase
    end
    return d;
  endfunction

  function automatic logic disp_raises_error(input disp_e d);
    return (d == DISP_UR) || (d == DISP_UC);
  endfunction

  // An error event may be reported unless the bridge sleeps and the
  // event did not come from packet receipt.
  function automatic logic err_permitted(input logic low_power, input logic rx_cause);
    return rx_cause || !low_power;
  endfunction

endpackage

// File: rtl/lpf_classify.sv
module lpf_classify
  import lpf_pkg::*;
(
  input  hdr_t  hdr,
  input  logic  low_power,
  output disp_e code,
  output logic  err_ok
);

  disp_e code_full;
  disp_e code_low;

  always_comb begin
    code_full = disp_full_power(hdr);
    code_low  = disp_low_power(hdr);
    code      = low_power ? code_low : code_full;
    err_ok    = disp_raises_error(code);
  end

endmodule

// File: rtl/lpf_disp_hold.sv
module lpf_disp_hold
  import lpf_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  disp_e            code_in,
  input  logic             err_ok_in,
  input  logic [TAG_W-1:0] tag_in,
  output logic             valid_q,
  output disp_e            code_q,
  output logic             err_ok_q,
  output logic [TAG_W-1:0] tag_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      code_q   <= DISP_ACCEPT;
      err_ok_q <= 1'b0;
      tag_q    <= '0;
    end else if (load) begin
      valid_q  <= 1'b1;
      code_q   <= code_in;
      err_ok_q <= err_ok_in;
      tag_q    <= tag_in;
    end
  end

endmodule

// File: rtl/lpf_err_gate.sv
module lpf_err_gate
  import lpf_pkg::*;
#(
  parameter int ERR_SRCS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                low_power,
  input  logic [ERR_SRCS-1:0] evt,
  input  logic [ERR_SRCS-1:0] rx_cause,
  output logic [ERR_SRCS-1:0] fire_q
);

  logic [ERR_SRCS-1:0] pass_en;

  for (genvar i = 0; i < ERR_SRCS; i++) begin : g_src
    assign pass_en[i] = err_permitted(low_power, rx_cause[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) fire_q[i] <= 1'b0;
      else        fire_q[i] <= evt[i] & pass_en[i];
    end
  end

endmodule

// File: rtl/lpf_filter.sv
module lpf_filter
  import lpf_pkg::*;
#(
  parameter int TAG_W    = 8,
  parameter int ERR_SRCS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pm_d3hot,
  input  logic                hdr_valid,
  input  logic [1:0]          hdr_kind,
  input  logic                hdr_cfg_type0,
  input  logic                hdr_to_self,
  input  logic                hdr_from_secondary,
  input  logic [TAG_W-1:0]    hdr_tag,
  input  logic [ERR_SRCS-1:0] err_evt,
  input  logic [ERR_SRCS-1:0] err_from_rx,
  output logic                disp_valid,
  output logic [1:0]          disp_code,
  output logic                disp_err_ok,
  output logic [TAG_W-1:0]    disp_tag,
  output logic [ERR_SRCS-1:0] err_fire
);

  hdr_t  cur_hdr;
  disp_e cls_code;
  logic  cls_err_ok;
  disp_e held_code;

  assign cur_hdr = '{kind:     pkt_kind_e'(hdr_kind),
                     cfg_t0:   hdr_cfg_type0,
                     to_self:  hdr_to_self,
                     from_sec: hdr_from_secondary};

  lpf_classify u_classify (
    .hdr       (cur_hdr),
    .low_power (pm_d3hot),
    .code      (cls_code),
    .err_ok    (cls_err_ok)
  );

  lpf_disp_hold #(.TAG_W(TAG_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (hdr_valid),
    .code_in   (cls_code),
    .err_ok_in (cls_err_ok),
    .tag_in    (hdr_tag),
    .valid_q   (disp_valid),
    .code_q    (held_code),
    .err_ok_q  (disp_err_ok),
    .tag_q     (disp_tag)
  );

  assign disp_code = held_code;

  lpf_err_gate #(.ERR_SRCS(ERR_SRCS)) u_err_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .low_power (pm_d3hot),
    .evt       (err_evt),
    .rx_cause  (err_from_rx),
    .fire_q    (err_fire)
  );

endmodule

// File: rtl/lpf_filter_chk.sv
module lpf_filter_chk #(
  parameter int TAG_W    = 8,
  parameter int ERR_SRCS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pm_d3hot,
  input logic                hdr_valid,
  input logic [1:0]          hdr_kind,
  input logic                hdr_cfg_type0,
  input logic                hdr_to_self,
  input logic                hdr_from_secondary,
  input logic [TAG_W-1:0]    hdr_tag,
  input logic [ERR_SRCS-1:0] err_evt,
  input logic [ERR_SRCS-1:0] err_from_rx,
  input logic                disp_valid,
  input logic [1:0]          disp_code,
  input logic                disp_err_ok,
  input logic [TAG_W-1:0]    disp_tag,
  input logic [ERR_SRCS-1:0] err_fire
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> disp_valid && (disp_tag == $past(hdr_tag)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_valid && disp_valid) |=> disp_valid && $stable(disp_code) && $stable(disp_tag));

  assert_cfg0_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && pm_d3hot && !hdr_from_secondary && hdr_kind == 2'b01 && hdr_cfg_type0)
      |=> disp_code == 2'b00);

  assert_secondary_ur_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && pm_d3hot && hdr_from_secondary && hdr_kind != 2'b11)
      |=> disp_code == 2'b10);

  assert_cpl_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && pm_d3hot && hdr_kind == 2'b11 && hdr_to_self) |=> disp_code == 2'b11);

  assert_cpl_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_kind == 2'b11 && !hdr_to_self) |=> disp_code == 2'b01);

  assert_err_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_err_ok == disp_code[1]));

  assert_err_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pm_d3hot |=> ((err_fire & ~$past(err_from_rx)) == '0));

  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_fire) |-> ((err_fire & ~$past(err_evt)) == '0));

endmodule

bind lpf_filter lpf_filter_chk #(.TAG_W(TAG_W), .ERR_SRCS(ERR_SRCS)) u_lpf_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .pm_d3hot           (pm_d3hot),
  .hdr_valid          (hdr_valid),
  .hdr_kind           (hdr_kind),
  .hdr_cfg_type0      (hdr_cfg_type0),
  .hdr_to_self        (hdr_to_self),
  .hdr_from_secondary (hdr_from_secondary),
  .hdr_tag            (hdr_tag),
  .err_evt            (err_evt),
  .err_from_rx        (err_from_rx),
  .disp_valid         (disp_valid),
  .disp_code          (disp_code),
  .disp_err_ok        (disp_err_ok),
  .disp_tag           (disp_tag),
  .err_fire           (err_fire)
);

// File: tb/test_lpf_filter.sv
`timescale 1ns/1ps
module test_lpf_filter;

  localparam int TW = 6;
  localparam int NS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pm_d3hot = 1'b0;
  logic          hdr_valid = 1'b0;
  logic [1:0]    hdr_kind = 2'b00;
  logic          hdr_cfg_type0 = 1'b0;
  logic          hdr_to_self = 1'b0;
  logic          hdr_from_secondary = 1'b0;
  logic [TW-1:0] hdr_tag = '0;
  logic [NS-1:0] err_evt = '0;
  logic [NS-1:0] err_from_rx = '0;
  logic          disp_valid;
  logic [1:0]    disp_code;
  logic          disp_err_ok;
  logic [TW-1:0] disp_tag;
  logic [NS-1:0] err_fire;

  int n_checks = 0;
  int n_fails  = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  lpf_filter #(.TAG_W(TW), .ERR_SRCS(NS)) i_lpf_filter (
    .clk(clk), .rst_n(rst_n), .pm_d3hot(pm_d3hot), .hdr_valid(hdr_valid),
    .hdr_kind(hdr_kind), .hdr_cfg_type0(hdr_cfg_type0), .hdr_to_self(hdr_to_self),
    .hdr_from_secondary(hdr_from_secondary), .hdr_tag(hdr_tag),
    .err_evt(err_evt), .err_from_rx(err_from_rx), .disp_valid(disp_valid),
    .disp_code(disp_code), .disp_err_ok(disp_err_ok), .disp_tag(disp_tag),
    .err_fire(err_fire)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected disposition restated from the requirements.
  function automatic logic [1:0] expect_code(input logic [1:0] k, input logic t0,
      input logic self_t, input logic sec, input logic d3);
    if (k == 2'b11 && !self_t) return 2'b01;          // R9
    if (!d3) return self_t ? 2'b00 : 2'b01;           // R3
    if (k == 2'b11) return 2'b11;                     // R8
    if (sec) return 2'b10;                            // R7
    if (k == 2'b01) return t0 ? 2'b00 : 2'b10;        // R4
    if (k == 2'b10) return self_t ? 2'b00 : 2'b10;    // R5
    return 2'b10;                                     // R6
  endfunction

  function automatic string req_of(input logic [1:0] k, input logic self_t,
      input logic sec, input logic d3);
    if (k == 2'b11 && !self_t) return "R9";
    if (!d3) return "R3";
    if (k == 2'b11) return "R8";
    if (sec) return "R7";
    if (k == 2'b01) return "R4";
    if (k == 2'b10) return "R5";
    return "R6";
  endfunction

  // Drive one header on a falling edge, check results one falling edge later.
  task automatic send_hdr(input logic [1:0] k, input logic t0, input logic self_t,
      input logic sec, input logic d3, input logic [TW-1:0] tag);
    logic [1:0] e;
    e = expect_code(k, t0, self_t, sec, d3);
    @(negedge clk);
    pm_d3hot = d3; hdr_kind = k; hdr_cfg_type0 = t0; hdr_to_self = self_t;
    hdr_from_secondary = sec; hdr_tag = tag; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    check(req_of(k, self_t, sec, d3), int'(disp_code), int'(e));
    check("R2 valid", int'(disp_valid), 1);
    check("R2 tag", int'(disp_tag), int'(tag));
    check("R10", int'(disp_err_ok), int'(e[1]));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    err_evt = '1; err_from_rx = '1;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(disp_valid), 0);
    check("R1 fire in reset", int'(err_fire), 0);
    err_evt = '0; err_from_rx = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(disp_valid), 0);
    check("R1 fire after reset", int'(err_fire), 0);
  endtask

  task automatic t_sweep(input logic d3);
    for (int i = 0; i < 32; i++) begin
      send_hdr(i[4:3], i[2], i[1], i[0], d3, TW'(i + (d3 ? 32 : 0)));
    end
  endtask

  task automatic t_targeted;
    send_hdr(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 6'd7);   // R7: message to self from secondary
    send_hdr(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 6'd8);   // R4: type0 not marked self
    send_hdr(2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 6'd9);   // R6: request to self
    send_hdr(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 6'd10);  // R8: completion to self, secondary
    send_hdr(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 6'd11);  // R9 in D0
  endtask

  task automatic t_hold;
    send_hdr(2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 6'd21);  // unexpected completion held
    @(negedge clk);
    pm_d3hot = 1'b0; hdr_kind = 2'b00; hdr_to_self = 1'b0;
    hdr_from_secondary = 1'b1; hdr_tag = 6'd3;
    repeat (4) @(negedge clk);
    check("R2 hold code", int'(disp_code), 3);
    check("R2 hold tag", int'(disp_tag), 21);
    check("R2 hold valid", int'(disp_valid), 1);
    check("R10 hold", int'(disp_err_ok), 1);
  endtask

  task automatic t_errors;
    for (int d = 0; d < 2; d++) begin
      for (int ev = 0; ev < 8; ev++) begin
        for (int rx = 0; rx < 8; rx++) begin
          logic [NS-1:0] want;
          want = NS'(ev) & ((d == 1) ? NS'(rx) : '1);
          @(negedge clk);
          pm_d3hot = (d == 1); err_evt = NS'(ev); err_from_rx = NS'(rx);
          @(negedge clk);
          err_evt = '0; err_from_rx = '0;
          check("R11 fire", int'(err_fire), int'(want));
        end
      end
    end
    @(negedge clk);
    check("R11 idle", int'(err_fire), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_targeted();
    t_hold();
    t_errors();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule